// File: doc/BRIEF.md
# Carry-Save Residue-Sum Modular Multiplier

This block computes A·B mod M for one channel of a residue-number-system datapath, with N-bit operands and N set between 4 and 24. It works bit-serially: the bits of A are taken one per clock, starting with the most significant. For each bit, the running value is doubled and B is added when that bit is set. The running value stays in carry-save form, as a sum word and a carry word. After each step the two top bits of each word are cleared, and what they weighed is put back in the next step as a residue read from a small table. No carry-propagate adder and no subtraction of M sit in the loop.

On `start`, a setup sequencer builds two seven-entry residue tables from M by repeated modular doubling and addition. One table holds k·2^N mod M and the other holds k·2^(N−1) mod M. If the next job uses the same M, setup is skipped. One final binary addition gives a result congruent to A·B that is below 2^(N+1). With `FULL_REDUCE` set, a bit-serial remainder stage then brings the result below M.

Top module: `rns_sor_mulmod`

## Requirements
- R1: With FULL_REDUCE=1, `result` equals (A·B) mod M for every N-bit A and B, including values of A or B at or above M, and for every nonzero M, including M=1 and M=2^N−1.
- R2: With FULL_REDUCE=0, `result` is below 2^(N+1) and is congruent to A·B modulo M.
- R3: `done` is high for exactly one cycle per job, and `busy` is low in that cycle. `busy` is high from the cycle after `start` is taken until then. `result` holds its value until the next job ends.
- R4: If setup runs, `done` rises on the 3N+8th rising edge after the edge that samples `start` when FULL_REDUCE=1, and on the 2N+7th edge when FULL_REDUCE=0.
- R5: If `start` brings the same M as the last job, and no reset has come since, setup is skipped. `done` then rises on edge 2N+2 when FULL_REDUCE=1, and on edge N+1 when FULL_REDUCE=0.
- R6: `start` while `busy` is high is ignored. The running job's result is unchanged, no extra `done` follows, and the tables stay as they were.
- R7: While `rst_n` is low, `busy`, `done` and `result` are 0. The first job after reset always runs setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Takes op_a, op_b and modulus when idle |
| op_a | input | N | Multiplier operand, scanned from the MSB |
| op_b | input | N | Multiplicand |
| modulus | input | N | Modulus M, must be nonzero |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | N+1 | Product modulo M, fully or partially reduced |

## Verification
The bench aims at the moduli where sum-of-residues reduction goes wrong most easily. These are M=1 and M=2, where a single final subtraction is far from enough, and M=2^N−1, the largest value a table entry can take. Operands at or above M also show whether a design quietly assumes they are already reduced. A wrong table entry, or a dropped top-bit weight, gives results that are off by a multiple of a power of two modulo M. Back-to-back jobs with the same M, with a new M, and straight after a reset check the table-reuse decision: a wrong decision shows up as a latency off by N+6 cycles, or as results computed from stale tables. A `start` pulse in the middle of a job catches a design that takes in new operands while busy.

// File: rtl/rns_sor_mulmod.sv
module rns_sor_mulmod #(
  parameter int N = 8,
  parameter bit FULL_REDUCE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic [N-1:0] modulus,
  output logic         busy,
  output logic         done,
  output logic [N:0]   result
);
  localparam int CW = $clog2(N + 1);
  localparam int AW = $clog2(N);

  typedef enum logic [2:0] {ST_IDLE, ST_DBL, ST_FILL, ST_MUL, ST_FIN, ST_RED} state_t;

  state_t       st;
  logic [N-1:0] a_q, b_q, m_q, h_q, g_q;
  logic [N-1:0] tab_lo [0:6];
  logic [N-1:0] tab_hi [0:6];
  logic [2:0]   k_q, q_q;
  logic [CW-1:0] cnt;
  logic         tab_ok, done_q;
  logic [N-2:0] s_q, c_q;
  logic [N:0]   raw_q, rem_q, res_q;

  function automatic logic [N-1:0] mod_add(input logic [N-1:0] x, input logic [N-1:0] y,
                                           input logic [N-1:0] md);
    logic [N:0] t;
    t = {1'b0, x} + {1'b0, y};
    if (t >= {1'b0, md}) t = t - {1'b0, md};
    return t[N-1:0];
  endfunction

  logic [N-1:0] x1, y1, z1, s1, r1;
  logic [N:0]   c1, s2, c2, fin, rsh, rem_nx;
  logic [2:0]   q_nx;

  assign x1 = {s_q, 1'b0};
  assign y1 = {c_q, 1'b0};
  assign z1 = a_q[cnt[AW-1:0]] ? b_q : '0;
  assign s1 = x1 ^ y1 ^ z1;
  assign c1 = {(x1 & y1) | (x1 & z1) | (y1 & z1), 1'b0};
  assign r1 = tab_hi[q_q];
  assign s2 = {c1[N], s1 ^ c1[N-1:0] ^ r1};
  assign c2 = {(s1 & c1[N-1:0]) | (s1 & r1) | (c1[N-1:0] & r1), 1'b0};
  assign q_nx = {1'b0, s2[N:N-1]} + {1'b0, c2[N:N-1]};
  assign fin = {2'b0, s_q} + {2'b0, c_q} + {1'b0, tab_lo[q_q]};
  assign rsh = {rem_q[N-1:0], raw_q[cnt]};
  assign rem_nx = (rsh >= {1'b0, m_q}) ? rsh - {1'b0, m_q} : rsh;

  assign busy   = (st != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      a_q <= '0; b_q <= '0; m_q <= '0; h_q <= '0; g_q <= '0;
      k_q <= '0; q_q <= '0; cnt <= '0;
      tab_ok <= 1'b0; done_q <= 1'b0;
      s_q <= '0; c_q <= '0;
      raw_q <= '0; rem_q <= '0; res_q <= '0;
      for (int i = 0; i < 7; i++) begin
        tab_lo[i] <= '0;
        tab_hi[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          a_q <= op_a; b_q <= op_b; m_q <= modulus;
          s_q <= '0; c_q <= '0; q_q <= '0;
          cnt <= CW'(N - 1);
          if (tab_ok && modulus == m_q) begin
            st <= ST_MUL;
          end else begin
            tab_ok <= 1'b0;
            h_q <= (modulus == N'(1)) ? '0 : N'(1);
            st <= ST_DBL;
          end
        end
        ST_DBL: begin
          if (cnt != '0) begin
            h_q <= mod_add(h_q, h_q, m_q);
            cnt <= cnt - 1'b1;
          end else begin
            g_q <= mod_add(h_q, h_q, m_q);
            tab_lo[0] <= '0;
            tab_hi[0] <= '0;
            k_q <= 3'd1;
            st <= ST_FILL;
          end
        end
        ST_FILL: begin
          tab_lo[k_q] <= mod_add(tab_lo[k_q - 3'd1], h_q, m_q);
          tab_hi[k_q] <= mod_add(tab_hi[k_q - 3'd1], g_q, m_q);
          if (k_q == 3'd6) begin
            tab_ok <= 1'b1;
            cnt <= CW'(N - 1);
            st <= ST_MUL;
          end else begin
            k_q <= k_q + 3'd1;
          end
        end
        ST_MUL: begin
          s_q <= s2[N-2:0];
          c_q <= c2[N-2:0];
          q_q <= q_nx;
          if (cnt == '0) st <= ST_FIN;
          else cnt <= cnt - 1'b1;
        end
        ST_FIN: begin
          raw_q <= fin;
          if (FULL_REDUCE) begin
            rem_q <= '0;
            cnt <= CW'(N);
            st <= ST_RED;
          end else begin
            res_q <= fin;
            done_q <= 1'b1;
            st <= ST_IDLE;
          end
        end
        ST_RED: begin
          rem_q <= rem_nx;
          if (cnt == '0) begin
            res_q <= rem_nx;
            done_q <= 1'b1;
            st <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_TOP_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MUL) |-> (q_q <= 3'd6)); // R2
  AST_RESIDUE_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MUL) |-> (tab_hi[q_q] < m_q)); // R1
  AST_FULL_BELOW_M: assert property (@(posedge clk) disable iff (!rst_n)
    (done && FULL_REDUCE) |-> (result < {1'b0, m_q})); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_BUSY_HOLDS_M: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(m_q)); // R6
endmodule

// File: tb/rns_sor_mulmod_bench.sv
module rns_sor_mulmod_bench;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N-1:0] op_a = '0, op_b = '0, modulus = 8'd1;
  logic busy_f, done_f, busy_r, done_r;
  logic [N:0] res_f, res_r;

  int checks = 0, errors = 0;
  bit m_valid = 1'b0;
  int m_last = 0;

  always #5 clk = ~clk;

  rns_sor_mulmod #(.N(N), .FULL_REDUCE(1'b1)) u_rns_sor_mulmod (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .modulus(modulus), .busy(busy_f), .done(done_f), .result(res_f));

  rns_sor_mulmod #(.N(N), .FULL_REDUCE(1'b0)) u_rns_sor_mulmod_raw (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .modulus(modulus), .busy(busy_r), .done(done_r), .result(res_r));

  function automatic int ref_mod(input int a, input int b, input int m);
    return int'((longint'(a) * longint'(b)) % longint'(m));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(busy_f == 0 && busy_r == 0, "R7 busy in reset", {busy_f, busy_r}, 0);
    check(done_f == 0 && done_r == 0, "R7 done in reset", {done_f, done_r}, 0);
    check(res_f == 0 && res_r == 0, "R7 result in reset", res_f + res_r, 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_valid = 1'b0;
  endtask

  task automatic run_job(input int a, input int b, input int m, input bit poke);
    bit hit;
    int cnt, lf, lr, exp;
    hit = m_valid && (m == m_last);
    @(negedge clk);
    op_a = N'(a); op_b = N'(b); modulus = N'(m); start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    cnt = 0; lf = 0; lr = 0;
    while ((lf == 0 || lr == 0) && cnt < 400) begin
      @(posedge clk);
      #1;
      cnt++;
      if (cnt == 1) check(busy_f && busy_r, "R3 busy after start", {busy_f, busy_r}, 3);
      if (poke && cnt == 3) begin
        op_a = ~N'(a); op_b = N'(b) ^ 8'h0F; modulus = N'(m) ^ 8'h33; start = 1'b1;
      end
      if (poke && cnt == 4) start = 1'b0;
      if (lf != 0 && cnt == lf + 1) check(!done_f, "R3 done one cycle", done_f, 0);
      if (lr != 0 && cnt == lr + 1) check(!done_r, "R3 done one cycle raw", done_r, 0);
      if (done_f && lf == 0) begin
        lf = cnt;
        check(!busy_f, "R3 busy low with done", busy_f, 0);
      end
      if (done_r && lr == 0) begin
        lr = cnt;
        check(!busy_r, "R3 busy low with done raw", busy_r, 0);
      end
    end
    if (cnt >= 400) check(1'b0, "R4 job timeout", cnt, 0);
    if (hit) begin
      check(lf == 2 * N + 2, "R5 reuse latency full", lf, 2 * N + 2);
      check(lr == N + 1, "R5 reuse latency raw", lr, N + 1);
    end else begin
      check(lf == 3 * N + 8, "R4 setup latency full", lf, 3 * N + 8);
      check(lr == 2 * N + 7, "R4 setup latency raw", lr, 2 * N + 7);
    end
    exp = ref_mod(a, b, m);
    check(int'(res_f) == exp, poke ? "R6 result after ignored start" : "R1 reduced product",
          res_f, exp);
    check(int'(res_r) < (1 << (N + 1)) && (int'(res_r) % m) == exp,
          "R2 partial product congruent", res_r, exp);
    m_valid = 1'b1;
    m_last = m;
  endtask

  initial begin
    int m, a, b, quiet;
    logic [N:0] held;
    void'($urandom(32'd1234));
    do_reset();
    run_job(0, 200, 251, 0);
    run_job(0, 200, 251, 0);
    run_job(77, 254, 255, 0);
    run_job(254, 254, 255, 0);
    run_job(255, 255, 2, 0);
    run_job(5, 7, 1, 0);
    run_job(255, 255, 1, 0);
    run_job(200, 3, 128, 0);
    run_job(255, 254, 3, 0);
    held = res_f;
    repeat (5) @(posedge clk);
    #1 check(res_f == held, "R3 result held", res_f, held);
    for (int i = 0; i < 150; i++) begin
      m = (($urandom % 4) == 0 && m_valid) ? m_last : 2 + int'($urandom % 254);
      if (i % 5 == 0) begin
        a = int'($urandom % 256); b = int'($urandom % 256);
      end else begin
        a = int'($urandom % m); b = int'($urandom % m);
      end
      run_job(a, b, m, 0);
    end
    run_job(123, 45, 211, 1);
    quiet = 0;
    for (int i = 0; i < 3 * N + 10; i++) begin
      @(posedge clk);
      #1 if (done_f || done_r) quiet++;
    end
    check(quiet == 0, "R6 no extra done", quiet, 0);
    run_job(99, 17, 211, 0);
    do_reset();
    run_job(99, 17, 211, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL R4 watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule